// File: doc/BRIEF.md
# Dual-Edge Sampled Phase-Frequency Detector

This block compares a reference clock against a divided feedback clock. Both arrive as single-bit signals that a fast system clock samples. Each input first passes through a synchronizer chain. An edge detector then turns each input into a one-cycle pulse for every active edge. A small state machine raises a lead pulse when the reference edge comes first and a lag pulse when the feedback edge comes first. The pulse lasts as many system-clock cycles as the gap between the two matching edges. When both sides have seen their edge, the state machine clears both outputs on that same clock edge.

A mode input chooses between two ways of comparing. In one, only rising edges are compared. In the other, rising and falling edges are both compared, so phase is corrected twice per input period. While a pulse is active, a saturating signed counter measures its width. When the pulse ends, the counter presents the result as a phase-error word together with a one-cycle valid strobe.

Edges from one input can arrive again before the other input answers. When that happens, the state persists across the extra edge, and the block latches a flag saying which input runs faster. This lets the loop controller tell a frequency offset apart from a plain phase offset. Edges that land in the same system-clock sample produce no pulse. That sample is the residual dead zone.

Top module: `dual_edge_pfd`

## Requirements
- R1: While reset is asserted and directly after it is released, `up`, `dn`, `err_valid`, `ref_fast`, `fb_fast` are 0 and `phase_err` is 0.
- R2: When the reference active edge is detected G>0 system cycles before the feedback active edge, `up` is high for exactly G cycles and `dn` stays low.
- R3: When the feedback active edge is detected G>0 cycles before the reference active edge, `dn` is high for exactly G cycles and `up` stays low.
- R4: When both active edges are detected in the same sample, neither `up` nor `dn` pulses, and `err_valid` still strobes once with `phase_err` equal to 0.
- R5: With `both_edges`=0 only rising (0 to 1) transitions are active. Falling transitions and steady levels produce no pulse and no strobe.
- R6: With `both_edges`=1, falling transitions are active edges as well and produce pulses by the same rules as R2 and R3.
- R7: `up` and `dn` are never high in the same cycle.
- R8: In the cycle after the clearing edge, `err_valid` is high for one cycle. `phase_err` is the two's-complement signed count of the pulse width: positive for `up`, negative for `dn`. The value holds until the next strobe.
- R9: `phase_err` saturates at 2^(CNT_W-1)-1 and at -2^(CNT_W-1).
- R10: A reference active edge arriving while `up` is already high sets `ref_fast` and clears `fb_fast`. A feedback active edge arriving while `dn` is already high sets `fb_fast` and clears `ref_fast`. Otherwise both flags hold their values.
- R11: An input transition sampled at system-clock edge t raises `up` or `dn` at edge t+SYNC_STAGES, one cycle after it leaves the synchronizer chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| both_edges | input | 1 | 0: rising edges only, 1: rising and falling edges |
| ref_clk_in | input | 1 | Reference clock, asynchronous to clk |
| fb_clk_in | input | 1 | Divided feedback clock, asynchronous to clk |
| up | output | 1 | Lead pulse: reference edge came first |
| dn | output | 1 | Lag pulse: feedback edge came first |
| phase_err | output | CNT_W | Signed width of the last pulse, saturating |
| err_valid | output | 1 | One-cycle strobe when `phase_err` updates |
| ref_fast | output | 1 | Reference seen faster than feedback |
| fb_fast | output | 1 | Feedback seen faster than reference |

## Verification
The bench builds the block with CNT_W=6 and SYNC_STAGES=3. The narrow counter brings both saturation limits (+31 and -32) within reach of gaps of about forty cycles, which are short enough for the run. The three-stage chain shows that the response latency follows the parameter rather than a fixed two-flop delay. Random gaps of up to twenty cycles either way, in both modes, are mixed with directed cases: coincident edges, ignored falling edges, double reference and double feedback edges that set the frequency flags, and saturation.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef enum logic {
      CMP_RISE_ONLY = 1'b0,
      CMP_BOTH      = 1'b1
   } cmp_mode_e;

   typedef struct packed {
      logic lead;
      logic lag;
   } pfd_pulse_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync
   import pfd_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  cmp_mode_e mode,
   input  logic      din,
   output logic      act_edge
);

   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] chain;
   logic              prev_q;
   logic              rise_w;
   logic              fall_w;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfd_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= 1'b0;
      end else begin
         chain[0] <= din;
      end
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[i] <= 1'b0;
            end else begin
               chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= chain[LAST];
      end
   end

   assign rise_w = chain[LAST] & ~prev_q;
   assign fall_w = ~chain[LAST] & prev_q;

   always_comb begin
      unique case (mode)
         CMP_BOTH:      act_edge = rise_w | fall_w;
         CMP_RISE_ONLY: act_edge = rise_w;
         default:       act_edge = rise_w;
      endcase
   end

endmodule

// File: rtl/pfd_core.sv
module pfd_core
   import pfd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_e,
   input  logic       fb_e,
   output pfd_pulse_t pulse_q,
   output logic       clr_evt,
   output logic       ref_fast,
   output logic       fb_fast
);

   pfd_pulse_t nxt;
   logic       ref_slip;
   logic       fb_slip;

   always_comb begin
      nxt.lead = pulse_q.lead | ref_e;
      nxt.lag  = pulse_q.lag  | fb_e;
      clr_evt  = nxt.lead & nxt.lag;
      if (clr_evt) begin
         nxt = '0;
      end
   end

   assign ref_slip = ref_e & pulse_q.lead & ~fb_e;
   assign fb_slip  = fb_e  & pulse_q.lag  & ~ref_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= '0;
      end else begin
         pulse_q <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_fast <= 1'b0;
         fb_fast  <= 1'b0;
      end else if (ref_slip) begin
         ref_fast <= 1'b1;
         fb_fast  <= 1'b0;
      end else if (fb_slip) begin
         ref_fast <= 1'b0;
         fb_fast  <= 1'b1;
      end
   end

   // R7
   never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pulse_q.lead && pulse_q.lag));

   // R2
   lead_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q.lead) |-> $past(ref_e));

   // R3
   lag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q.lag) |-> $past(fb_e));

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ref_fast, fb_fast}));

   // R10
   ref_fast_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_fast) |-> $past(pulse_q.lead));

endmodule

// File: rtl/pfd_errcnt.sv
module pfd_errcnt #(
   parameter int CNT_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lead_q,
   input  logic                    lag_q,
   input  logic                    clr_evt,
   output logic signed [CNT_W-1:0] phase_err,
   output logic                    err_valid
);

   localparam int WW   = CNT_W + 1;
   localparam int MAXI = (1 << (CNT_W - 1)) - 1;
   localparam int MINI = -(1 << (CNT_W - 1));
   localparam logic signed [WW-1:0] MAX_W = WW'(MAXI);
   localparam logic signed [WW-1:0] MIN_W = WW'(MINI);

   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("pfd_errcnt: CNT_W must be at least 3");
      end
   endgenerate

   logic signed [CNT_W-1:0] acc_q;
   logic signed [WW-1:0]    step;
   logic signed [WW-1:0]    wide;
   logic signed [CNT_W-1:0] sat_val;

   always_comb begin
      if (lead_q) begin
         step = {{CNT_W{1'b0}}, 1'b1};
      end else if (lag_q) begin
         step = {WW{1'b1}};
      end else begin
         step = '0;
      end
      wide = {acc_q[CNT_W-1], acc_q} + step;
      if (wide > MAX_W) begin
         sat_val = MAX_W[CNT_W-1:0];
      end else if (wide < MIN_W) begin
         sat_val = MIN_W[CNT_W-1:0];
      end else begin
         sat_val = wide[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         phase_err <= '0;
         err_valid <= 1'b0;
      end else if (clr_evt) begin
         acc_q     <= '0;
         phase_err <= sat_val;
         err_valid <= 1'b1;
      end else begin
         acc_q     <= sat_val;
         err_valid <= 1'b0;
      end
   end

   // R8
   lead_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lead_q) |-> (err_valid && phase_err > 0));

   // R8
   lag_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lag_q) |-> (err_valid && phase_err < 0));

   // R8
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !err_valid |-> $stable(phase_err));

endmodule

// File: rtl/dual_edge_pfd.sv
module dual_edge_pfd
   import pfd_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    both_edges,
   input  logic                    ref_clk_in,
   input  logic                    fb_clk_in,
   output logic                    up,
   output logic                    dn,
   output logic signed [CNT_W-1:0] phase_err,
   output logic                    err_valid,
   output logic                    ref_fast,
   output logic                    fb_fast
);

   cmp_mode_e  mode;
   logic       ref_e;
   logic       fb_e;
   logic       clr_evt;
   pfd_pulse_t pulse_q;

   assign mode = both_edges ? CMP_BOTH : CMP_RISE_ONLY;

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .din      (ref_clk_in),
      .act_edge (ref_e)
   );

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .din      (fb_clk_in),
      .act_edge (fb_e)
   );

   pfd_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_e    (ref_e),
      .fb_e     (fb_e),
      .pulse_q  (pulse_q),
      .clr_evt  (clr_evt),
      .ref_fast (ref_fast),
      .fb_fast  (fb_fast)
   );

   pfd_errcnt #(.CNT_W(CNT_W)) u_errcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .lead_q    (pulse_q.lead),
      .lag_q     (pulse_q.lag),
      .clr_evt   (clr_evt),
      .phase_err (phase_err),
      .err_valid (err_valid)
   );

   assign up = pulse_q.lead;
   assign dn = pulse_q.lag;

   // R4
   same_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_e && fb_e && !up && !dn) |=> (!up && !dn && err_valid && phase_err == 0));

endmodule

// File: tb/dual_edge_pfd_test.sv
`timescale 1ns/1ps
module dual_edge_pfd_test;

   localparam int W    = 6;
   localparam int S    = 3;
   localparam int MAXV = (1 << (W - 1)) - 1;
   localparam int MINV = -(1 << (W - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic both_edges = 1'b0;
   logic ref_clk_in = 1'b0;
   logic fb_clk_in = 1'b0;
   logic up, dn, err_valid, ref_fast, fb_fast;
   logic signed [W-1:0] phase_err;

   int checks = 0;
   int errors = 0;
   int up_cnt = 0;
   int dn_cnt = 0;
   int val_cnt = 0;
   int both_cnt = 0;
   logic signed [W-1:0] last_err = '0;
   bit done = 0;
   bit lvl = 0;

   always #2 clk = ~clk;

   dual_edge_pfd #(.CNT_W(W), .SYNC_STAGES(S)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .both_edges (both_edges),
      .ref_clk_in (ref_clk_in),
      .fb_clk_in  (fb_clk_in),
      .up         (up),
      .dn         (dn),
      .phase_err  (phase_err),
      .err_valid  (err_valid),
      .ref_fast   (ref_fast),
      .fb_fast    (fb_fast)
   );

   always @(negedge clk) begin
      if (up) up_cnt++;
      if (dn) dn_cnt++;
      if (up && dn) both_cnt++;
      if (err_valid) begin
         val_cnt++;
         last_err = phase_err;
      end
   end

   function automatic int exp_err(int g);
      if (g > MAXV) return MAXV;
      if (g < MINV) return MINV;
      return g;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      up_cnt = 0;
      dn_cnt = 0;
      val_cnt = 0;
   endtask

   task automatic settle();
      repeat (S + 6) @(negedge clk);
      #1;
   endtask

   // drive a pair of transitions to level v, gap>0 means reference first
   task automatic run_pair(int gap, bit v, bit mode, string req);
      bit active;
      @(negedge clk);
      both_edges = mode;
      clear_mon();
      if (gap >= 0) begin
         ref_clk_in = v;
         repeat (gap) @(negedge clk);
         fb_clk_in = v;
      end else begin
         fb_clk_in = v;
         repeat (-gap) @(negedge clk);
         ref_clk_in = v;
      end
      settle();
      active = mode || v;
      if (active) begin
         check(up_cnt == (gap > 0 ? gap : 0), {req, " up width"}, up_cnt, gap > 0 ? gap : 0);
         check(dn_cnt == (gap < 0 ? -gap : 0), {req, " dn width"}, dn_cnt, gap < 0 ? -gap : 0);
         check(val_cnt == 1, {req, " R8 strobe count"}, val_cnt, 1);
         check(int'(last_err) == exp_err(gap), {req, " R8 phase_err"}, int'(last_err), exp_err(gap));
      end else begin
         check(up_cnt == 0 && dn_cnt == 0, {req, " R5 ignored edge pulses"}, up_cnt + dn_cnt, 0);
         check(val_cnt == 0, {req, " R5 ignored edge strobe"}, val_cnt, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      // R1 during reset
      check(!up && !dn && !err_valid, "R1 outputs in reset", int'({up, dn, err_valid}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!up && !dn && !err_valid && !ref_fast && !fb_fast, "R1 flags after reset",
            int'({up, dn, err_valid, ref_fast, fb_fast}), 0);
      check(phase_err == 0, "R1 phase_err after reset", int'(phase_err), 0);

      // R11 latency: change at negedge, sampled at next edge t, up rises at t+S
      @(negedge clk);
      clear_mon();
      ref_clk_in = 1'b1;
      repeat (S) @(posedge clk);
      #1;
      check(!up, "R11 up before latency", int'(up), 0);
      @(posedge clk);
      #1;
      check(up, "R11 up at latency", int'(up), 1);
      @(negedge clk);
      fb_clk_in = 1'b1;
      settle();
      run_pair(0, 1'b0, 1'b0, "R5 fall both");

      // directed rising-only cases
      run_pair(4, 1'b1, 1'b0, "R2 lead 4");
      run_pair(-5, 1'b0, 1'b0, "R5 falling lag");
      run_pair(-6, 1'b1, 1'b0, "R3 lag 6");
      run_pair(3, 1'b0, 1'b0, "R5 falling lead");
      run_pair(0, 1'b1, 1'b0, "R4 coincident rise");
      run_pair(0, 1'b0, 1'b0, "R5 coincident fall");
      run_pair(1, 1'b1, 1'b0, "R2 lead 1");
      run_pair(0, 1'b0, 1'b0, "R5 reset level");

      // R6 both-edge mode
      run_pair(5, 1'b1, 1'b1, "R6 rise lead");
      run_pair(-7, 1'b0, 1'b1, "R6 fall lag");
      run_pair(0, 1'b1, 1'b1, "R4 R6 coincident rise");
      run_pair(2, 1'b0, 1'b1, "R6 fall lead");

      // R9 saturation
      run_pair(40, 1'b1, 1'b1, "R9 positive limit");
      run_pair(-40, 1'b0, 1'b1, "R9 negative limit");

      // R10 reference faster: two reference rises before one feedback rise
      @(negedge clk);
      both_edges = 1'b0;
      clear_mon();
      ref_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      ref_clk_in = 1'b0;
      repeat (3) @(negedge clk);
      ref_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      fb_clk_in = 1'b1;
      settle();
      check(ref_fast && !fb_fast, "R10 ref_fast set", int'({ref_fast, fb_fast}), 2);
      check(up_cnt == 9 && int'(last_err) == 9, "R10 R2 slip width", up_cnt, 9);
      run_pair(0, 1'b0, 1'b0, "R5 lower after slip");
      check(ref_fast && !fb_fast, "R10 flag holds", int'({ref_fast, fb_fast}), 2);

      // R10 feedback faster
      @(negedge clk);
      clear_mon();
      fb_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      fb_clk_in = 1'b0;
      repeat (3) @(negedge clk);
      fb_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      ref_clk_in = 1'b1;
      settle();
      check(fb_fast && !ref_fast, "R10 fb_fast set", int'({ref_fast, fb_fast}), 1);
      check(dn_cnt == 9 && int'(last_err) == -9, "R10 R3 slip width", int'(last_err), -9);
      run_pair(0, 1'b0, 1'b0, "R5 lower after second slip");

      // random mix of modes and gaps
      lvl = 1'b0;
      for (int k = 0; k < 60; k++) begin
         int gap;
         bit mode;
         gap  = int'($urandom % 41) - 20;
         mode = bit'($urandom % 2);
         if (mode) begin
            lvl = ~lvl;
            run_pair(gap, lvl, 1'b1, "R2 R3 R6 random both");
         end else begin
            if (lvl) begin
               run_pair(int'($urandom % 21) - 10, 1'b0, 1'b0, "R5 random fall");
            end
            run_pair(gap, 1'b1, 1'b0, "R2 R3 random rise");
            lvl = 1'b1;
         end
      end

      check(both_cnt == 0, "R7 up and dn overlap", both_cnt, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule